// File: doc/BRIEF.md
# Serial Flash Single-Byte Cycle Sequencer

This block runs one complete single-byte access to a serial flash over a four-wire SPI link. The requester presents an opcode, a 24-bit address, a direction flag and, for a write, one data byte. The block then produces the whole command frame in hardware: opcode, three address bytes and a fifth byte that carries either the write data or a dummy byte during which the read data is clocked in. A byte-wide shift register inside the block handles the serial framing.

Chip-select stays low for the whole frame, so the memory never sees a break between the command, address and data bytes. The link runs in clock mode 0: the serial clock idles low, outgoing bits change on its falling edge and incoming bits are sampled on its rising edge. When chip-select returns high, a one-cycle strobe reports completion and, for a read, presents the received byte. A minimum deselect time is then enforced before the next request is taken.

Top module: `sfc_seq`

## Requirements
- R1: The first 8 bits shifted out on mosi_o after chip-select falls are opcode_i, most significant bit first.
- R2: The next 24 bits are addr_i sent as three bytes, bits 23:16 first, then 15:8, then 7:0, each byte MSB first.
- R3: When wr_i is 1 (write), the fifth byte shifted out is wdata_i, MSB first.
- R4: When wr_i is 0 (read), mosi_o is low throughout the fifth byte, and rd_data_o takes the 8 bits sampled from miso_i during that byte, the first one as the MSB. After a write, rd_data_o keeps its previous value.
- R5: cs_n_o stays low without a break for exactly 40 rising edges of sclk_o. sclk_o idles low and toggles only while cs_n_o is low, mosi_o changes only while sclk_o is low, and miso_i is sampled on the rising edge.
- R6: Bits received on miso_i during the opcode and address bytes have no effect on rd_data_o.
- R7: A request on req_i is taken only in a cycle where ready_o is 1. A request raised while a cycle is in progress starts no second frame and does not alter the frame in progress.
- R8: done_o is high for exactly one clock, in the same cycle in which cs_n_o returns high, and rd_data_o is valid in that cycle.
- R9: After each frame, cs_n_o stays high for at least two sclk_o periods (4*HALF_DIV clocks) before it can fall again, and ready_o is 0 while this time runs.
- R10: After reset cs_n_o is 1, sclk_o is 0, done_o is 0 and ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a cycle; taken when ready_o is 1 |
| wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| opcode_i | input | 8 | Command byte |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 8 | Data byte for a write |
| ready_o | output | 1 | Idle and able to take a request |
| done_o | output | 1 | One-cycle completion strobe |
| rd_data_o | output | 8 | Byte received in the last read |
| cs_n_o | output | 1 | Flash chip-select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
A byte index or bit counter that drifts shows up within the same frame as the wrong number of clock edges under chip-select, or as opcode, address or data bits landing in the wrong byte of the captured stream. A shifter that loads or shifts on the wrong clock phase corrupts the captured stream at the first byte boundary, and a wrong read path returns response bits from the address bytes in rd_data_o at the very next done strobe. A state machine that leaves its deselect state early or late shows up as a gap shorter than four half-periods, or as a done strobe that is not aligned with the chip-select rising edge.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_GAP
  } sfc_state_e;
endpackage

// File: rtl/sfc_tick_gen.sv
module sfc_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (HALF_DIV <= 1) begin : g_full
      assign tick_o = run_i;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (!run_i)      cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = run_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sfc_byte_shift.sv
module sfc_byte_shift
  import sfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_next_o
);
  logic [BYTE_W-1:0] sh_q;
  logic              miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      if (sample_i) miso_q <= miso_i;
      if (load_i)       sh_q <= load_byte_i;
      else if (shift_i) sh_q <= {sh_q[BYTE_W-2:0], miso_q};
    end
  end

  assign mosi_o    = sh_q[BYTE_W-1];
  // value after the pending shift: the full received byte at the last edge
  assign rx_next_o = {sh_q[BYTE_W-2:0], miso_q};
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int HALF_DIV   = 2,
  parameter int GAP_SCLK   = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         wr_i,
  input  logic [BYTE_W-1:0]            opcode_i,
  input  logic [ADDR_BYTES*BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0]            wdata_i,
  output logic                         ready_o,
  output logic                         done_o,
  output logic [BYTE_W-1:0]            rd_data_o,
  output logic                         cs_n_o,
  output logic                         sclk_o,
  output logic                         mosi_o,
  input  logic                         miso_i
);
  localparam int NBYTES    = ADDR_BYTES + 2;
  localparam int NBITS     = NBYTES * BYTE_W;
  localparam int GAP_TICKS = 2 * GAP_SCLK;
  localparam int BI_W      = $clog2(NBYTES);
  localparam int BT_W      = $clog2(BYTE_W);
  localparam int GC_W      = $clog2(GAP_TICKS + 1);
  localparam logic [BI_W-1:0] LAST_BYTE = BI_W'(NBYTES - 1);
  localparam logic [BT_W-1:0] LAST_BIT  = BT_W'(BYTE_W - 1);
  localparam logic [GC_W-1:0] LAST_GAP  = GC_W'(GAP_TICKS - 1);

  sfc_state_e        st_q;
  logic [NBITS-1:0]  frame_q;
  logic              wr_q;
  logic [BI_W-1:0]   byte_idx_q, nxt_idx;
  logic [BT_W-1:0]   bit_idx_q;
  logic [GC_W-1:0]   gap_q;
  logic              cs_n_q, sclk_q, done_q;
  logic [BYTE_W-1:0] rd_q;

  logic              tick, accept, rise, fall, last_bit, last_byte;
  logic              sh_load, sh_shift, sh_mosi;
  logic [BYTE_W-1:0] load_byte, rx_next;
  logic [BYTE_W-1:0] frame_bytes [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
    assign frame_bytes[g] = frame_q[NBITS-1-g*BYTE_W -: BYTE_W];
  end

  sfc_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != ST_IDLE),
    .tick_o (tick)
  );

  always_comb begin
    accept    = (st_q == ST_IDLE) && req_i;
    rise      = (st_q == ST_XFER) && tick && !sclk_q;
    fall      = (st_q == ST_XFER) && tick && sclk_q;
    last_bit  = (bit_idx_q == LAST_BIT);
    last_byte = (byte_idx_q == LAST_BYTE);
    nxt_idx   = last_byte ? '0 : byte_idx_q + 1'b1;
    // at a byte boundary the next frame byte replaces the shift
    sh_load   = accept || (fall && last_bit && !last_byte);
    sh_shift  = fall && !(last_bit && !last_byte);
    load_byte = accept ? opcode_i : frame_bytes[nxt_idx];
  end

  sfc_byte_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (sh_load),
    .load_byte_i (load_byte),
    .sample_i    (rise),
    .shift_i     (sh_shift),
    .miso_i      (miso_i),
    .mosi_o      (sh_mosi),
    .rx_next_o   (rx_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      frame_q    <= '0;
      wr_q       <= 1'b0;
      byte_idx_q <= '0;
      bit_idx_q  <= '0;
      gap_q      <= '0;
      cs_n_q     <= 1'b1;
      sclk_q     <= 1'b0;
      done_q     <= 1'b0;
      rd_q       <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          frame_q    <= {opcode_i, addr_i, (wr_i ? wdata_i : {BYTE_W{1'b0}})};
          wr_q       <= wr_i;
          byte_idx_q <= '0;
          bit_idx_q  <= '0;
          cs_n_q     <= 1'b0;
          st_q       <= ST_XFER;
        end
        ST_XFER: begin
          if (rise) sclk_q <= 1'b1;
          if (fall) begin
            sclk_q <= 1'b0;
            if (!last_bit) begin
              bit_idx_q <= bit_idx_q + 1'b1;
            end else if (!last_byte) begin
              bit_idx_q  <= '0;
              byte_idx_q <= nxt_idx;
            end else begin
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
              gap_q  <= '0;
              if (!wr_q) rd_q <= rx_next;
              st_q   <= ST_GAP;
            end
          end
        end
        ST_GAP: if (tick) begin
          if (gap_q == LAST_GAP) st_q <= ST_IDLE;
          else                   gap_q <= gap_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o   = (st_q == ST_IDLE);
  assign done_o    = done_q;
  assign rd_data_o = rd_q;
  assign cs_n_o    = cs_n_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = sh_mosi && !cs_n_q;
endmodule

// File: rtl/sfc_seq_chk.sv
module sfc_seq_chk #(
  parameter int HALF_DIV = 2,
  parameter int GAP_SCLK = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic ready_o,
  input logic done_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic mosi_o
);
  localparam int GAP_CLKS = 2 * GAP_SCLK * (HALF_DIV < 1 ? 1 : HALF_DIV);
  localparam int HW = $clog2(GAP_CLKS + 2);
  localparam logic [HW-1:0] SAT = HW'(GAP_CLKS + 1);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           hi_cnt <= SAT;
    else if (!cs_n_o)      hi_cnt <= '0;
    else if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
  end

  // R9
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> hi_cnt >= HW'(GAP_CLKS));

  // R8
  done_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(cs_n_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  sclk_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_n_o);

  // R5
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  // R7
  start_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> $past(req_i && ready_o));

  // R10
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cs_n_o && !sclk_o));
endmodule

bind sfc_seq sfc_seq_chk #(.HALF_DIV(HALF_DIV), .GAP_SCLK(GAP_SCLK)) u_chk (.*);

// File: tb/sfc_seq_test.sv
module sfc_seq_test;
  localparam int HALF_DIV = 2;
  localparam int NBITS    = 40;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic        wr;
    logic [7:0]  wd;
    logic [39:0] resp;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{8'h02, 24'h123456, 1'b1, 8'hA5, 40'hFFFFFFFF00},
    '{8'h03, 24'hABCDEF, 1'b0, 8'h00, 40'h12345678C3},
    '{8'h02, 24'h000001, 1'b1, 8'h00, 40'h0000000000},
    '{8'h0B, 24'hFFFFFF, 1'b0, 8'hEE, 40'hFFFFFFFF5A},
    '{8'h03, 24'h800000, 1'b0, 8'h00, 40'h00000000FF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, miso;
  logic [7:0]  op = '0, wd = '0;
  logic [23:0] addr = '0;
  logic ready, done, cs_n, sclk, mosi;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  int bit_cnt = 0, frames = 0, sclk_outside = 0;
  int hi_run = 0, min_gap = 1000000;
  bit seen_end = 0;
  logic [39:0] cap = '0, resp = '0;
  logic [7:0]  exp_rd = '0;

  always #2 clk = ~clk;

  sfc_seq #(.HALF_DIV(HALF_DIV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr),
    .opcode_i(op), .addr_i(addr), .wdata_i(wd),
    .ready_o(ready), .done_o(done), .rd_data_o(rd_data),
    .cs_n_o(cs_n), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso)
  );

  // flash model: present bit on miso, capture mosi on rising sclk
  assign miso = (bit_cnt < NBITS) ? resp[NBITS-1-bit_cnt] : 1'b0;

  always @(negedge cs_n) begin
    bit_cnt = 0;
    frames++;
  end

  always @(posedge sclk) begin
    if (cs_n) sclk_outside++;
    cap = {cap[38:0], mosi};
    bit_cnt++;
  end

  always @(negedge clk) begin
    if (cs_n) hi_run++;
    else begin
      if (hi_run > 0 && seen_end && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input bit poke);
    int f0, t;
    resp = v.resp;
    @(negedge clk);
    while (!ready) @(negedge clk);
    f0 = frames;
    op = v.op; addr = v.addr; wr = v.wr; wd = v.wd; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      op = 8'hD8; addr = 24'h555555; wr = 1'b1; wd = 8'h3C; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check(done, "R8 done seen", done, 1);
    check(cs_n == 1'b1, "R8 cs high at done", cs_n, 1);
    check(bit_cnt == NBITS, "R5 sclk edges in frame", bit_cnt, NBITS);
    check(frames == f0 + 1, "R5 single cs low window", frames - f0, 1);
    check(cap[39:32] == v.op, "R1 opcode", cap[39:32], v.op);
    check(cap[31:8] == v.addr, "R2 address", cap[31:8], v.addr);
    if (v.wr) check(cap[7:0] == v.wd, "R3 write data", cap[7:0], v.wd);
    else begin
      check(cap[7:0] == 8'h00, "R4 dummy byte", cap[7:0], 0);
      exp_rd = v.resp[7:0];
    end
    check(rd_data == exp_rd, "R4 R6 rd_data", rd_data, exp_rd);
    seen_end = 1;
    @(negedge clk);
    check(!done, "R8 done one cycle", done, 0);
    check(!ready, "R9 ready low in gap", ready, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    check(cs_n == 1'b1, "R10 cs_n reset", cs_n, 1);
    check(sclk == 1'b0, "R10 sclk reset", sclk, 0);
    check(done == 1'b0, "R10 done reset", done, 0);
    check(ready == 1'b1, "R10 ready reset", ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) run(VECS[i], 1'b0);

    // R9 back-to-back frames above
    check(min_gap >= 4 * HALF_DIV, "R9 deselect gap", min_gap, 4 * HALF_DIV);
    check(sclk_outside == 0, "R5 sclk only under cs", sclk_outside, 0);

    // R7 request while busy: no second frame, first one intact
    begin
      int f1;
      run('{8'h03, 24'h0A0B0C, 1'b0, 8'h00, 40'hAAAAAAAA96}, 1'b1);
      f1 = frames;
      repeat (60) @(negedge clk);
      check(frames == f1, "R7 busy request ignored", frames - f1, 0);
      check(ready, "R7 idle after busy poke", ready, 1);
    end

    // R4 write leaves rd_data unchanged
    run('{8'h02, 24'h00FF00, 1'b1, 8'h81, 40'hFFFFFFFFFF}, 1'b0);
    check(rd_data == 8'h96, "R4 rd_data held after write", rd_data, 8'h96);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule